// File: doc/BRIEF.md
# Hazard Stall-Scope Controller

This block sits in the control path of a pipelined processor. It collects hazard detect flags from up to eight sources, such as issue queues, ALUs, the load/store unit, decode and completion. Each flag becomes a stall whose reach is chosen per source at configuration time.

A small table holds two fields for every source. The first is the hazard class the source reports. The second is the stall scope to apply when that source fires. The scope can be nothing, a hold on that operation alone, a stall of the owning unit, a stall of the owning pipe, or a freeze of the whole machine.

The block also carries a fixed load-use interlock for a simple in-order pipe. A load in execute reserved its destination register while it was in decode. If the instruction now in decode reads that register, the decode stage and every stage before it hold. A bubble goes into the stage after decode, and the later stages keep moving.

Hazard flags are registered once on entry. All stall outputs are combinational from those registered flags and the table, so a stall appears in the cycle after the flag is presented.

Source i belongs to unit `i % NUM_UNITS`. Unit u belongs to pipe `u % NUM_PIPES`.

Top module: `hazard_scope_ctrl`

## Requirements
- R1: After reset every table entry holds class RAW (0) and scope none (0). With the defaults, any pattern of hazard flags drives all stall outputs low.
- R2: The class field encodes 0 = RAW, 1 = WAR, 2 = WAW and 3 = read-after-read. A source whose class is 3 never causes a stall, whatever its scope.
- R3: Scope code 1 raises `op_hold[i]` for source i in the cycle after its flag is sampled high.
- R4: Scope code 2 raises `unit_stall[i % NUM_UNITS]`.
- R5: Scope code 3 raises `pipe_stall[(i % NUM_UNITS) % NUM_PIPES]` only. Other pipes stay free.
- R6: Scope code 4 raises `global_stall`. While it is high, every `op_hold`, `unit_stall` and `pipe_stall` bit is low, and `front_hold` is high.
- R7: The widest scope wins. An operation hold is dropped when its unit or its pipe is stalled. A unit stall is dropped when its pipe is stalled.
- R8: Scope code 0 lets the source pass with no stall, even when its class is RAW.
- R9: A load in execute with destination d, together with a valid decode instruction that uses d as either source operand, raises `front_hold` and `nop_insert` in the same cycle.
- R10: There is no load-use interlock when execute holds no load, when neither used operand matches, or when d is register 0 and `ZERO_REG_FIXED` is set.
- R11: Scope codes 5 to 7 behave as global stall.
- R12: A table write with `cfg_we` high takes effect at the next clock edge. A flag sampled at that same edge already uses the new entry.
- R13: `nop_insert` is low while `global_stall` is high, because no stage advances.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_we | input | 1 | Table write enable |
| cfg_addr | input | SRC_AW | Source index to write |
| cfg_class | input | 2 | Hazard class code |
| cfg_scope | input | 3 | Stall scope code |
| haz_flag | input | NUM_SRC | Raw hazard detect flags, one per source |
| ex_load_valid | input | 1 | Execute stage holds a load |
| ex_rd | input | REG_AW | Load destination register |
| id_valid | input | 1 | Decode stage holds an instruction |
| id_rs1 | input | REG_AW | Decode first source register |
| id_rs1_used | input | 1 | First source operand is read |
| id_rs2 | input | REG_AW | Decode second source register |
| id_rs2_used | input | 1 | Second source operand is read |
| op_hold | output | NUM_SRC | Per-operation hold |
| unit_stall | output | NUM_UNITS | Per-unit stall |
| pipe_stall | output | NUM_PIPES | Per-pipe stall |
| global_stall | output | 1 | Whole-machine freeze |
| front_hold | output | 1 | Decode and earlier stages hold |
| nop_insert | output | 1 | Bubble request for the stage after decode |

## Verification
Single sources are programmed one scope at a time, so each output can be traced to one code. Mixed patterns with several sources firing together then show the widest-scope suppression between operation, unit, pipe and global. A long pseudo-random phase mixes table writes with flags, which exposes write-to-use timing and class-3 masking. Load-use cases separate a match on the first operand, a match on the second, operands that are present but unused, register 0, and the case with no load in execute.

// File: rtl/hsc_pkg.sv
package hsc_pkg;
   typedef enum logic [1:0] {
      CLS_RAW = 2'd0,
      CLS_WAR = 2'd1,
      CLS_WAW = 2'd2,
      CLS_RAR = 2'd3
   } hz_class_e;

   typedef enum logic [2:0] {
      SCP_NONE   = 3'd0,
      SCP_OP     = 3'd1,
      SCP_UNIT   = 3'd2,
      SCP_PIPE   = 3'd3,
      SCP_GLOBAL = 3'd4
   } scope_e;

   // Codes above global are folded onto global (safe side).
   function automatic scope_e sat_scope(input logic [2:0] code);
      if (code > 3'd4) return SCP_GLOBAL;
      return scope_e'(code);
   endfunction
endpackage

// File: rtl/hsc_table.sv
module hsc_table
   import hsc_pkg::*;
#(
   parameter int NUM_SRC = 8,
   parameter int SRC_AW  = (NUM_SRC > 1) ? $clog2(NUM_SRC) : 1
) (
   input  logic                     clk,
   input  logic                     rst_n,
   input  logic                     wr_en,
   input  logic [SRC_AW-1:0]        wr_idx,
   input  logic [1:0]               wr_class,
   input  logic [2:0]               wr_scope,
   input  logic [NUM_SRC-1:0]       flag_q,
   output logic [NUM_SRC-1:0][2:0]  eff_scope
);
   hz_class_e cls_q [NUM_SRC];
   scope_e    scp_q [NUM_SRC];

   for (genvar g = 0; g < NUM_SRC; g++) begin : g_ent
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            cls_q[g] <= CLS_RAW;
            scp_q[g] <= SCP_NONE;
         end else if (wr_en && (wr_idx == SRC_AW'(g))) begin
            cls_q[g] <= hz_class_e'(wr_class);
            scp_q[g] <= sat_scope(wr_scope);
         end
      end

      // A read-after-read entry never produces a stall.
      always_comb begin
         if (flag_q[g] && (cls_q[g] != CLS_RAR)) eff_scope[g] = scp_q[g];
         else                                    eff_scope[g] = SCP_NONE;
      end

      assert_write_lands_R12 : assert property (@(posedge clk) disable iff (!rst_n)
         (wr_en && wr_idx == SRC_AW'(g)) |=> (scp_q[g] == sat_scope($past(wr_scope))));
      assert_rar_silent_R2 : assert property (@(posedge clk) disable iff (!rst_n)
         (cls_q[g] == CLS_RAR) |-> (eff_scope[g] == SCP_NONE));
   end
endmodule

// File: rtl/hsc_scope.sv
module hsc_scope
   import hsc_pkg::*;
#(
   parameter int NUM_SRC   = 8,
   parameter int NUM_UNITS = 4,
   parameter int NUM_PIPES = 2
) (
   input  logic                     clk,
   input  logic                     rst_n,
   input  logic [NUM_SRC-1:0][2:0]  eff_scope,
   output logic [NUM_SRC-1:0]       op_hold,
   output logic [NUM_UNITS-1:0]     unit_stall,
   output logic [NUM_PIPES-1:0]     pipe_stall,
   output logic                     global_stall
);
   logic                 any_global;
   logic [NUM_UNITS-1:0] unit_req;
   logic [NUM_PIPES-1:0] pipe_req;

   always_comb begin
      any_global = 1'b0;
      unit_req   = '0;
      pipe_req   = '0;
      for (int i = 0; i < NUM_SRC; i++) begin
         if (eff_scope[i] == SCP_GLOBAL) any_global = 1'b1;
         if (eff_scope[i] == SCP_UNIT)   unit_req[i % NUM_UNITS] = 1'b1;
         if (eff_scope[i] == SCP_PIPE)   pipe_req[(i % NUM_UNITS) % NUM_PIPES] = 1'b1;
      end
   end

   assign global_stall = any_global;

   for (genvar p = 0; p < NUM_PIPES; p++) begin : g_pipe
      assign pipe_stall[p] = pipe_req[p] & ~any_global;
   end

   for (genvar u = 0; u < NUM_UNITS; u++) begin : g_unit
      localparam int PU = u % NUM_PIPES;
      assign unit_stall[u] = unit_req[u] & ~pipe_req[PU] & ~any_global;
      assert_unit_yields_R7 : assert property (@(posedge clk) disable iff (!rst_n)
         unit_stall[u] |-> !pipe_stall[PU]);
   end

   for (genvar s = 0; s < NUM_SRC; s++) begin : g_op
      localparam int SU = s % NUM_UNITS;
      localparam int SP = SU % NUM_PIPES;
      assign op_hold[s] = (eff_scope[s] == SCP_OP) & ~unit_req[SU] & ~pipe_req[SP] & ~any_global;
      assert_op_yields_R7 : assert property (@(posedge clk) disable iff (!rst_n)
         op_hold[s] |-> (!unit_stall[SU] && !pipe_stall[SP]));
   end

   assert_global_alone_R6 : assert property (@(posedge clk) disable iff (!rst_n)
      global_stall |-> (op_hold == '0 && unit_stall == '0 && pipe_stall == '0));
endmodule

// File: rtl/hsc_loaduse.sv
module hsc_loaduse #(
   parameter int REG_AW         = 5,
   parameter bit ZERO_REG_FIXED = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              ex_load_valid,
   input  logic [REG_AW-1:0] ex_rd,
   input  logic              id_valid,
   input  logic [REG_AW-1:0] id_rs1,
   input  logic              id_rs1_used,
   input  logic [REG_AW-1:0] id_rs2,
   input  logic              id_rs2_used,
   output logic              interlock
);
   logic dst_live;
   logic hit;

   if (ZERO_REG_FIXED) begin : g_zero_fixed
      assign dst_live = (ex_rd != '0);
   end else begin : g_zero_plain
      assign dst_live = 1'b1;
   end

   assign hit = (id_rs1_used && (id_rs1 == ex_rd)) || (id_rs2_used && (id_rs2 == ex_rd));
   assign interlock = ex_load_valid & id_valid & dst_live & hit;

   assert_no_load_no_lock_R10 : assert property (@(posedge clk) disable iff (!rst_n)
      !ex_load_valid |-> !interlock);
endmodule

// File: rtl/hazard_scope_ctrl.sv
module hazard_scope_ctrl
   import hsc_pkg::*;
#(
   parameter int NUM_SRC        = 8,
   parameter int NUM_UNITS      = 4,
   parameter int NUM_PIPES      = 2,
   parameter int REG_AW         = 5,
   parameter bit ZERO_REG_FIXED = 1'b1,
   localparam int SRC_AW        = (NUM_SRC > 1) ? $clog2(NUM_SRC) : 1
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 cfg_we,
   input  logic [SRC_AW-1:0]    cfg_addr,
   input  logic [1:0]           cfg_class,
   input  logic [2:0]           cfg_scope,
   input  logic [NUM_SRC-1:0]   haz_flag,
   input  logic                 ex_load_valid,
   input  logic [REG_AW-1:0]    ex_rd,
   input  logic                 id_valid,
   input  logic [REG_AW-1:0]    id_rs1,
   input  logic                 id_rs1_used,
   input  logic [REG_AW-1:0]    id_rs2,
   input  logic                 id_rs2_used,
   output logic [NUM_SRC-1:0]   op_hold,
   output logic [NUM_UNITS-1:0] unit_stall,
   output logic [NUM_PIPES-1:0] pipe_stall,
   output logic                 global_stall,
   output logic                 front_hold,
   output logic                 nop_insert
);
   if (NUM_SRC < 1 || NUM_UNITS < 1 || NUM_PIPES < 1) begin : g_bad_count
      $error("hazard_scope_ctrl: every count must be at least 1");
   end
   if (NUM_UNITS > NUM_SRC || NUM_PIPES > NUM_UNITS) begin : g_bad_map
      $error("hazard_scope_ctrl: need NUM_PIPES <= NUM_UNITS <= NUM_SRC");
   end
   if (REG_AW < 1) begin : g_bad_reg
      $error("hazard_scope_ctrl: REG_AW must be positive");
   end

   logic [NUM_SRC-1:0]      flag_q;
   logic [NUM_SRC-1:0][2:0] eff_scope;
   logic                    lu_lock;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) flag_q <= '0;
      else        flag_q <= haz_flag;
   end

   hsc_table #(.NUM_SRC(NUM_SRC), .SRC_AW(SRC_AW)) u_table (
      .clk(clk), .rst_n(rst_n),
      .wr_en(cfg_we), .wr_idx(cfg_addr), .wr_class(cfg_class), .wr_scope(cfg_scope),
      .flag_q(flag_q), .eff_scope(eff_scope)
   );

   hsc_scope #(.NUM_SRC(NUM_SRC), .NUM_UNITS(NUM_UNITS), .NUM_PIPES(NUM_PIPES)) u_scope (
      .clk(clk), .rst_n(rst_n), .eff_scope(eff_scope),
      .op_hold(op_hold), .unit_stall(unit_stall), .pipe_stall(pipe_stall),
      .global_stall(global_stall)
   );

   hsc_loaduse #(.REG_AW(REG_AW), .ZERO_REG_FIXED(ZERO_REG_FIXED)) u_loaduse (
      .clk(clk), .rst_n(rst_n),
      .ex_load_valid(ex_load_valid), .ex_rd(ex_rd), .id_valid(id_valid),
      .id_rs1(id_rs1), .id_rs1_used(id_rs1_used),
      .id_rs2(id_rs2), .id_rs2_used(id_rs2_used),
      .interlock(lu_lock)
   );

   assign front_hold = lu_lock | global_stall;
   assign nop_insert = lu_lock & ~global_stall;

   assert_flag_sampled_R3 : assert property (@(posedge clk) disable iff (!rst_n)
      1'b1 |=> (flag_q == $past(haz_flag)));
   assert_bubble_holds_R9 : assert property (@(posedge clk) disable iff (!rst_n)
      nop_insert |-> front_hold);
   assert_frozen_no_bubble_R13 : assert property (@(posedge clk) disable iff (!rst_n)
      global_stall |-> (front_hold && !nop_insert));
endmodule

// File: tb/hazard_scope_ctrl_bench.sv
`timescale 1ns/1ps
module hazard_scope_ctrl_bench;
   localparam int NS = 8, NU = 4, NP = 2, RW = 5;

   logic clk = 1'b0, rst_n = 1'b0;
   logic cfg_we = 0; logic [2:0] cfg_addr = 0; logic [1:0] cfg_class = 0; logic [2:0] cfg_scope = 0;
   logic [NS-1:0] haz_flag = 0;
   logic ex_load_valid = 0, id_valid = 0, id_rs1_used = 0, id_rs2_used = 0;
   logic [RW-1:0] ex_rd = 0, id_rs1 = 0, id_rs2 = 0;
   logic [NS-1:0] op_hold; logic [NU-1:0] unit_stall; logic [NP-1:0] pipe_stall;
   logic global_stall, front_hold, nop_insert;

   int tests = 0, fails = 0;
   bit done = 0;
   int m_cls [NS];
   int m_scp [NS];
   bit m_flag [NS];

   always #4 clk = ~clk;

   hazard_scope_ctrl u_hazard_scope_ctrl (
      .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
      .cfg_class(cfg_class), .cfg_scope(cfg_scope), .haz_flag(haz_flag),
      .ex_load_valid(ex_load_valid), .ex_rd(ex_rd), .id_valid(id_valid),
      .id_rs1(id_rs1), .id_rs1_used(id_rs1_used), .id_rs2(id_rs2), .id_rs2_used(id_rs2_used),
      .op_hold(op_hold), .unit_stall(unit_stall), .pipe_stall(pipe_stall),
      .global_stall(global_stall), .front_hold(front_hold), .nop_insert(nop_insert));

   task automatic chk(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
      tests++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s %s actual=%0h expected=%0h at %0t", req, what, act, exp, $time);
      end
   endtask

   // Reference model: scope of each source, then widest-scope resolution.
   task automatic compare();
      int e [NS];
      bit g = 0, lu;
      bit ureq [NU];
      bit preq [NP];
      logic [NS-1:0] x_op = 0; logic [NU-1:0] x_unit = 0; logic [NP-1:0] x_pipe = 0;
      for (int u = 0; u < NU; u++) ureq[u] = 0;
      for (int p = 0; p < NP; p++) preq[p] = 0;
      for (int i = 0; i < NS; i++) begin
         e[i] = (!m_flag[i] || m_cls[i] == 3) ? 0 : (m_scp[i] > 4 ? 4 : m_scp[i]); // R2, R11
         if (e[i] == 4) g = 1;
         if (e[i] == 3) preq[(i % NU) % NP] = 1;
         if (e[i] == 2) ureq[i % NU] = 1;
      end
      for (int p = 0; p < NP; p++) x_pipe[p] = preq[p] && !g;
      for (int u = 0; u < NU; u++) x_unit[u] = ureq[u] && !preq[u % NP] && !g;
      for (int i = 0; i < NS; i++)
         x_op[i] = (e[i] == 1) && !ureq[i % NU] && !preq[(i % NU) % NP] && !g;
      lu = ex_load_valid && id_valid && (ex_rd != 0) &&
           ((id_rs1_used && id_rs1 == ex_rd) || (id_rs2_used && id_rs2 == ex_rd));
      chk("R3/R7 op", "op_hold", 32'(op_hold), 32'(x_op));
      chk("R4", "unit_stall", 32'(unit_stall), 32'(x_unit));
      chk("R5", "pipe_stall", 32'(pipe_stall), 32'(x_pipe));
      chk("R6", "global_stall", 32'(global_stall), 32'(g));
      chk("R9/R10", "front_hold", 32'(front_hold), 32'(lu || g));
      chk("R13", "nop_insert", 32'(nop_insert), 32'(lu && !g));
   endtask

   task automatic tick();
      @(posedge clk);
      if (!rst_n) begin
         for (int i = 0; i < NS; i++) begin m_cls[i] = 0; m_scp[i] = 0; m_flag[i] = 0; end
      end else begin
         if (cfg_we) begin m_cls[cfg_addr] = int'(cfg_class); m_scp[cfg_addr] = int'(cfg_scope); end
         for (int i = 0; i < NS; i++) m_flag[i] = haz_flag[i];
      end
      #1 compare();
   endtask

   task automatic cfg(input int idx, input int cls, input int scp);
      cfg_we = 1; cfg_addr = 3'(idx); cfg_class = 2'(cls); cfg_scope = 3'(scp);
      tick();
      cfg_we = 0;
   endtask

   task automatic flags(input logic [NS-1:0] f);
      haz_flag = f; tick(); tick();
   endtask

   task automatic lu(input bit ld, input int rd, input int a, input bit ua, input int b, input bit ub);
      ex_load_valid = ld; ex_rd = RW'(rd); id_valid = 1;
      id_rs1 = RW'(a); id_rs1_used = ua; id_rs2 = RW'(b); id_rs2_used = ub;
      tick();
   endtask

   initial begin
      #100000;
      fails++;
      $display("FAIL watchdog expired");
      if (!done) begin
         $display("  [TB] %0d tests run, %0d failed", tests, fails);
         $finish;
      end
   end

   initial begin
      logic [15:0] lfsr = 16'hACE1;
      tick(); tick();
      rst_n = 1;
      flags('1);                         // R1: default table gives no stall
      chk("R1", "global after reset", 32'(global_stall), 0);
      flags('0);
      cfg(0, 0, 1); flags(8'h01);        // R3 op hold on source 0
      chk("R3", "op_hold[0]", 32'(op_hold[0]), 1);
      cfg(1, 1, 2); flags(8'h02);        // R4 unit 1
      chk("R4", "unit_stall", 32'(unit_stall), 32'h2);
      cfg(2, 2, 3); flags(8'h04);        // R5 pipe 0 only
      chk("R5", "pipe_stall", 32'(pipe_stall), 32'h1);
      cfg(4, 0, 2); flags(8'h11);        // R7 unit 0 swallows op of source 0
      chk("R7", "op_hold", 32'(op_hold), 0);
      flags(8'h15);                      // R7 pipe 0 swallows unit 0
      chk("R7", "unit_stall", 32'(unit_stall), 0);
      cfg(3, 0, 4); flags(8'h1F);        // R6 global overrides
      chk("R6", "pipe_stall", 32'(pipe_stall), 0);
      cfg(5, 0, 0); flags(8'h20);        // R8 no action on RAW
      chk("R8", "front_hold", 32'(front_hold), 0);
      cfg(6, 3, 4); flags(8'h40);        // R2 read-after-read class masked
      chk("R2", "global_stall", 32'(global_stall), 0);
      cfg(7, 1, 6); flags(8'h80);        // R11 code 6 acts as global
      chk("R11", "global_stall", 32'(global_stall), 1);
      // R12: write and flag at the same edge
      haz_flag = 8'h80; cfg(7, 0, 1);
      chk("R12", "op_hold[7]", 32'(op_hold[7]), 1);
      haz_flag = 0; tick();
      lu(1, 7, 7, 1, 3, 1);  chk("R9", "nop_insert rs1", 32'(nop_insert), 1);
      lu(1, 9, 2, 1, 9, 1);  chk("R9", "nop_insert rs2", 32'(nop_insert), 1);
      lu(1, 9, 9, 0, 9, 0);  chk("R10", "unused operands", 32'(front_hold), 0);
      lu(1, 0, 0, 1, 0, 1);  chk("R10", "register 0", 32'(front_hold), 0);
      lu(0, 4, 4, 1, 4, 1);  chk("R10", "no load", 32'(front_hold), 0);
      haz_flag = 8'h08; lu(1, 4, 4, 1, 0, 0); tick();
      chk("R13", "bubble under freeze", 32'(nop_insert), 0);
      haz_flag = 0;
      for (int n = 0; n < 600; n++) begin
         lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
         cfg_we = lfsr[0] & lfsr[5]; cfg_addr = lfsr[3:1]; cfg_class = lfsr[7:6]; cfg_scope = lfsr[10:8];
         haz_flag = lfsr[15:8] & lfsr[7:0];
         ex_load_valid = lfsr[11]; ex_rd = RW'(lfsr[2:0]); id_valid = lfsr[12];
         id_rs1 = RW'(lfsr[5:3]); id_rs1_used = lfsr[13]; id_rs2 = RW'(lfsr[8:6]); id_rs2_used = lfsr[14];
         tick();
      end
      done = 1;
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
   end
endmodule